// File: doc/BRIEF.md
# Synchronized Even Clock Divider Channel

This block forms one output lane of a clock fan-out device. It receives the selected fast input clock and delivers one logical output clock. That output is either the input clock passed straight through or a copy divided by an even ratio. A two-bit route mode picks the path. The divide ratio is twice an eight-bit code, so the range runs from 2 to 510.

An active-low restart pin is shared by every lane. It holds all divided lanes low and then releases them so that their rising edges coincide. A short glitch on the pin is filtered out. The pin acts on its recognised level only after a fixed four-cycle latency. Lanes on the pass-through path ignore the pin.

The output is driven only when three things are true: the lane enable is set, the global enable bit is set and the global enable pin is high. A power-down bit forces the output off whatever the other inputs are. The fine analog delay and the differential drivers lie outside this block. For that reason the two delayed modes behave exactly like their undelayed twins.

Top module: `chdiv_channel`

## Requirements
- R1: In route modes 0 and 2 (pass-through), when the lane is on, `clk_out` follows `clk`: it is high in the first half of each input period and low in the second half.
- R2: In route modes 1 and 3 (divided), with code N in 1..255, `clk_out` is high for N input cycles and then low for N input cycles, repeating. The period is 2×N. The first high phase begins at the first rising edge after a restart.
- R3: With divider code 0 in a divided mode, `clk_out` stays low and never toggles.
- R4: A low level on `sync_n` is recognised only at a rising edge where `sync_n` is sampled low and was also sampled low at the previous rising edge. A low level lasting only one cycle has no effect on the output.
- R5: Four rising edges after the edge at which the low is recognised, the divided output is forced low. It stays low while the recognition persists.
- R6: When `sync_n` is first sampled high again, the divided output goes high at the fourth rising edge after that edge. This is the restart edge of R2.
- R7: In pass-through modes, `sync_n` has no effect on `clk_out`.
- R8: `clk_out` is low at all times unless `ch_en`, `glb_en` and `glb_oe_pin` are all 1 and `pwr_dn` is 0.
- R9: While `rst_n` is low the divided output is low. The restart filter starts in the released state, so the first rising edge after reset release starts a high phase.
- R10: Mode 2 behaves identically to mode 0, and mode 3 behaves identically to mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Shared active-low restart pin, synchronous to clk |
| ch_en | input | 1 | Lane enable bit |
| glb_en | input | 1 | Global enable bit |
| glb_oe_pin | input | 1 | Global enable pin, active high |
| pwr_dn | input | 1 | Power-down bit, forces output off |
| mode | input | 2 | Route mode: 0 pass, 1 divided, 2 pass delayed, 3 divided delayed |
| div_code | input | 8 | Divider code N, ratio 2×N, 0 is illegal |
| clk_out | output | 1 | Logical output clock |

## Verification
The assertions assume that `sync_n`, the enables and the configuration fields change only away from the rising edge of `clk`. They also assume that the divider code is altered only while a restart hold is in force. The bench drives every input on the falling edge. It changes `div_code` only after `sync_n` has been low long enough for the hold to be active, and releases `sync_n` only after the new code is in place. Under these conditions the cycle model's phase count stays valid from one restart to the next.

// File: rtl/chdiv_pkg.sv
`timescale 1ns/1ps
package chdiv_pkg;
  typedef enum logic [1:0] {
    ROUTE_PASS     = 2'd0,
    ROUTE_DIV      = 2'd1,
    ROUTE_PASS_DLY = 2'd2,
    ROUTE_DIV_DLY  = 2'd3
  } route_mode_t;

  // Bit 0 of the route mode selects the divided path; the delay bit is
  // analog and has no digital effect.
  function automatic logic route_uses_div(input route_mode_t m);
    return (m == ROUTE_DIV) || (m == ROUTE_DIV_DLY);
  endfunction
endpackage

// File: rtl/chdiv_sync_align.sv
`timescale 1ns/1ps
module chdiv_sync_align #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic filt,
  output logic hold
);
  localparam int STAGES = (LAT > 1) ? LAT - 1 : 1;

  logic             prev_s;
  logic [STAGES-1:0] line;

  // R4: low is recognised only after two consecutive low samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= 1'b1;
      filt   <= 1'b1;
    end else begin
      prev_s <= sync_n;
      filt   <= sync_n | prev_s;
    end
  end

  // R5/R6: fixed latency between recognition and the divider
  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line[gi] <= 1'b1;
        else        line[gi] <= filt;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line[gi] <= 1'b1;
        else        line[gi] <= line[gi-1];
      end
    end
  end

  assign hold = ~line[STAGES-1];
endmodule

// File: rtl/chdiv_even_div.sv
`timescale 1ns/1ps
module chdiv_even_div #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [CODE_W-1:0] code,
  output logic              q
);
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic [CODE_W-1:0] cnt;
  logic              prime;
  logic              code_ok;
  logic              wrap;

  assign code_ok = (code != '0);
  assign wrap    = (cnt >= code - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      q     <= 1'b0;
      prime <= 1'b1;
    end else if (hold || !code_ok) begin
      // R5 / R3: forced low, restart armed
      cnt   <= '0;
      q     <= 1'b0;
      prime <= 1'b1;
    end else if (prime) begin
      // R6 / R9: first edge after restart rises
      cnt   <= '0;
      q     <= 1'b1;
      prime <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      q   <= ~q;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/chdiv_out_gate.sv
`timescale 1ns/1ps
module chdiv_out_gate
  import chdiv_pkg::*;
(
  input  logic        clk,
  input  logic        div_q,
  input  route_mode_t mode,
  input  logic        ch_en,
  input  logic        glb_en,
  input  logic        glb_oe_pin,
  input  logic        pwr_dn,
  output logic        clk_out
);
  logic lane_on;
  logic routed;

  assign lane_on = ch_en & glb_en & glb_oe_pin & ~pwr_dn;   // R8
  assign routed  = route_uses_div(mode) ? div_q : clk;       // R1 R2 R10
  assign clk_out = lane_on & routed;
endmodule

// File: rtl/chdiv_channel.sv
`timescale 1ns/1ps
module chdiv_channel
  import chdiv_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SYNC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              ch_en,
  input  logic              glb_en,
  input  logic              glb_oe_pin,
  input  logic              pwr_dn,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] div_code,
  output logic              clk_out
);
  logic sync_filt;
  logic sync_hold;
  logic div_q;

  chdiv_sync_align #(.LAT(SYNC_LAT)) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .filt   (sync_filt),
    .hold   (sync_hold)
  );

  chdiv_even_div #(.CODE_W(CODE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (sync_hold),
    .code  (div_code),
    .q     (div_q)
  );

  chdiv_out_gate u_gate (
    .clk        (clk),
    .div_q      (div_q),
    .mode       (route_mode_t'(mode)),
    .ch_en      (ch_en),
    .glb_en     (glb_en),
    .glb_oe_pin (glb_oe_pin),
    .pwr_dn     (pwr_dn),
    .clk_out    (clk_out)
  );
endmodule

// File: rtl/chdiv_channel_chk.sv
`timescale 1ns/1ps
module chdiv_channel_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_n,
  input logic              ch_en,
  input logic              glb_en,
  input logic              glb_oe_pin,
  input logic              pwr_dn,
  input logic [CODE_W-1:0] div_code,
  input logic              clk_out,
  input logic              sync_filt,
  input logic              sync_hold,
  input logic              div_q
);
  p_code_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == '0) |=> !div_q);

  p_two_low_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_filt |-> (!$past(sync_n) && !$past(sync_n, 2)));

  p_hold_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |=> !div_q);

  p_release_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_hold && $past(sync_hold) && (div_code != '0)) |=> div_q);

  p_gate_off_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (pwr_dn || !ch_en || !glb_en || !glb_oe_pin) |-> !clk_out);
endmodule

bind chdiv_channel chdiv_channel_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_n     (sync_n),
  .ch_en      (ch_en),
  .glb_en     (glb_en),
  .glb_oe_pin (glb_oe_pin),
  .pwr_dn     (pwr_dn),
  .div_code   (div_code),
  .clk_out    (clk_out),
  .sync_filt  (sync_filt),
  .sync_hold  (sync_hold),
  .div_q      (div_q)
);

// File: tb/chdiv_channel_test.sv
`timescale 1ns/1ps
module chdiv_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic       ch_en = 1'b1;
  logic       glb_en = 1'b1;
  logic       glb_oe_pin = 1'b1;
  logic       pwr_dn = 1'b0;
  logic [1:0] mode = 2'd1;
  logic [7:0] div_code = 8'd1;
  logic       clk_out;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string tag = "R9";

  // reference model state
  int  since = -1;
  bit  expq = 0;
  bit  prev_s = 1;
  bit  recq[$] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;   // 200 MHz

  chdiv_channel uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .ch_en(ch_en),
    .glb_en(glb_en), .glb_oe_pin(glb_oe_pin), .pwr_dn(pwr_dn),
    .mode(mode), .div_code(div_code), .clk_out(clk_out)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: clk_out=%b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic bit lane_on();
    return ch_en && glb_en && glb_oe_pin && !pwr_dn;
  endfunction

  // model step and high-phase comparison
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      since = -1; expq = 0; prev_s = 1; recq = '{0, 0, 0, 0};
      check(clk_out, 1'b0, "R9");
    end else begin
      bit held;
      bit rec;
      held = recq[3];
      rec = (sync_n == 1'b0) && (prev_s == 1'b0);
      prev_s = sync_n;
      recq.push_front(rec);
      void'(recq.pop_back());
      if (held || div_code == 8'd0) begin
        since = -1; expq = 0;
      end else begin
        since++;
        expq = ((since / int'(div_code)) % 2) == 0;
      end
      check(clk_out, lane_on() && (mode[0] ? expq : 1'b1), tag);
    end
  end

  // low-phase comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) check(clk_out, lane_on() && mode[0] && expq, tag);
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // change the code only while the restart hold is in force
  task automatic restart_with(input logic [7:0] code, input string t);
    sync_n = 1'b0;
    cycles(8);
    div_code = code;
    cycles(2);
    tag = t;
    sync_n = 1'b1;
  endtask

  initial begin
    tag = "R9";
    cycles(4);
    rst_n = 1'b1;
    cycles(20);                       // R9 first rise, R2 with N=1
    tag = "R10"; mode = 2'd3; cycles(10);
    tag = "R1";  mode = 2'd0; cycles(10);
    tag = "R10"; mode = 2'd2; cycles(10);
    tag = "R5";  mode = 2'd1;
    restart_with(8'd3, "R6");         // R5 hold, R6 aligned rise
    cycles(30);
    tag = "R2"; cycles(20);
    tag = "R4";                       // single-cycle low is filtered
    sync_n = 1'b0; cycles(1); sync_n = 1'b1;
    cycles(20);
    tag = "R7"; mode = 2'd0;          // pass-through ignores restart
    sync_n = 1'b0; cycles(12); sync_n = 1'b1; cycles(8);
    mode = 2'd1;
    restart_with(8'd0, "R3"); cycles(25);
    restart_with(8'd5, "R2"); cycles(40);
    tag = "R8";
    ch_en = 1'b0;      cycles(6); ch_en = 1'b1;
    glb_en = 1'b0;     cycles(6); glb_en = 1'b1;
    glb_oe_pin = 1'b0; cycles(6); glb_oe_pin = 1'b1;
    mode = 2'd0;
    pwr_dn = 1'b1;     cycles(6); pwr_dn = 1'b0;
    ch_en = 1'b0;      cycles(6); ch_en = 1'b1;
    mode = 2'd1;
    restart_with(8'd255, "R2"); cycles(1100);
    tag = "R10"; mode = 2'd3; cycles(600);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule